// File: doc/BRIEF.md
# MLC Page-Pair Error Level Corrector

This block performs the cell-level repair step of a joint correction scheme for two pages that live in the same group of two-bit flash cells. One page holds the most significant bit of every cell and the other holds the least significant bit. A wide-correction decoder outside this block works on the bitwise XOR of the two pages. It returns a mask that flags the cells it found in error. The block streams the cells through, one beat per accepted handshake. Each flagged cell is moved one voltage level by a fixed state map, and unflagged cells pass through untouched. The corrected MSB and LSB pages then go to the narrower per-page decoders.

The block also prepares the check words for those per-page passes. It keeps the first-code redundancy word, which the MSB page is decoded with as it is. It also keeps the second-code redundancy word. One cycle after both words are held, it provides their combination for the LSB page: the first word XORed with the low-order slice of the second word. A combinational output gives the XOR of the incoming pages, which is the word the wide-correction decoder needs.

Top module: `mlc_pair_level_fix`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0, `par_valid` is 0 and `in_ready` is 1.
- R2: A cell whose `in_flag` bit is 0 leaves with the same MSB and LSB it arrived with.
- R3: Cell state is written as {MSB, LSB}, and the levels from lowest to highest voltage are 11, 10, 00, 01. A flagged cell in state 11 leaves as 10, and a flagged cell in state 10 leaves as 11.
- R4: A flagged cell in state 00 leaves as 10, and a flagged cell in state 01 leaves as 00. No flagged cell ever leaves in state 01.
- R5: `sum_bits` equals `in_msb ^ in_lsb` in the same cycle, with bit i belonging to cell lane i.
- R6: A beat accepted at a clock edge (`in_valid` and `in_ready` both 1) is presented on the outputs from that edge onward. Beats leave once each, in acceptance order. `in_ready` is 1 whenever the output register is empty or `out_ready` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat (`out_msb`, `out_lsb`, `out_eop`) holds unchanged on the next cycle.
- R8: `out_eop` leaves with the same beat whose `in_eop` was 1.
- R9: `msb_par` shows the last loaded first-code word. One cycle after both redundancy words have been loaded, `par_valid` is 1 and `lsb_par` equals the first-code word XOR bits [R1_W-1:0] of the second-code word. With only one word ever loaded, `par_valid` stays 0.
- R10: A load of either word drops `par_valid` at that clock edge. It returns to 1 on the following edge, with the recomputed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_msb | input | LANES | MSB bits of the incoming cells |
| in_lsb | input | LANES | LSB bits of the incoming cells |
| in_flag | input | LANES | Error-location mask from the wide decoder |
| in_eop | input | 1 | Marks the last beat of a page |
| sum_bits | output | LANES | XOR of incoming MSB and LSB bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_msb | output | LANES | Corrected MSB bits |
| out_lsb | output | LANES | Corrected LSB bits |
| out_eop | output | 1 | Last-beat marker aligned with the output |
| red1_ld | input | 1 | Load strobe for the first-code word |
| red1_in | input | R1_W | First-code redundancy word |
| red2_ld | input | 1 | Load strobe for the second-code word |
| red2_in | input | R2_W | Second-code redundancy word |
| msb_par | output | R1_W | Check word for the MSB page |
| lsb_par | output | R1_W | Combined check word for the LSB page |
| par_valid | output | 1 | `lsb_par` is current |

## Verification
The bench drives every one of the four cell states, both flagged and unflagged. A map that swapped the two middle-level targets, or that sent a flagged 01 cell anywhere but 00, would give a wrong output bit. Random stall patterns on `out_ready` expose a stage that overwrites a held beat or loses one when a new beat is accepted in the same cycle as a drain. The same patterns catch an end-of-page marker that is dropped or shifted by one beat. On the parity side, the bench loads only one word first, reloads a single word and loads both words together. These cases catch a valid flag that rises too early, one that fails to drop on reload, or the wrong slice of the second word.

// File: rtl/mlc_fix_pkg.sv
package mlc_fix_pkg;

    // Cell state as {msb, lsb}, listed from lowest to highest threshold voltage.
    typedef enum logic [1:0] {
        ST_ERASED = 2'b11,
        ST_LOW    = 2'b10,
        ST_MID    = 2'b00,
        ST_HIGH   = 2'b01
    } cell_state_e;

endpackage

// File: rtl/mlc_level_remap.sv
module mlc_level_remap
    import mlc_fix_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] in_msb,
    input  logic [LANES-1:0] in_lsb,
    input  logic [LANES-1:0] in_flag,
    output logic [LANES-1:0] out_msb,
    output logic [LANES-1:0] out_lsb
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cell_state_e cur_s;
        cell_state_e nxt_s;

        always_comb begin
            cur_s = cell_state_e'({in_msb[g], in_lsb[g]});
            nxt_s = cur_s;
            if (in_flag[g]) begin
                case (cur_s)
                    ST_ERASED: nxt_s = ST_LOW;
                    ST_LOW:    nxt_s = ST_ERASED;
                    ST_MID:    nxt_s = ST_LOW;
                    default:   nxt_s = ST_MID;
                endcase
            end
        end

        assign out_msb[g] = nxt_s[1];
        assign out_lsb[g] = nxt_s[0];

        always_comb begin
            AST_FLAG_MOVES: assert (!in_flag[g] || (nxt_s != cur_s)); // R3
            AST_NO_TOP_TARGET: assert (!in_flag[g] || (nxt_s != ST_HIGH)); // R4
        end
    end

endmodule

// File: rtl/mlc_cell_stage.sv
module mlc_cell_stage #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] in_msb,
    input  logic [LANES-1:0] in_lsb,
    input  logic             in_eop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_msb,
    output logic [LANES-1:0] out_lsb,
    output logic             out_eop
);

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] msb;
        logic [LANES-1:0] lsb;
        logic             eop;
    } stage_t;

    stage_t stage_d, stage_q;

    assign in_ready = !stage_q.valid || out_ready;

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = stage_q.valid && !out_ready;
        if (in_valid && in_ready) begin
            stage_d.valid = 1'b1;
            stage_d.msb   = in_msb;
            stage_d.lsb   = in_lsb;
            stage_d.eop   = in_eop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_msb   = stage_q.msb;
    assign out_lsb   = stage_q.lsb;
    assign out_eop   = stage_q.eop;

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msb) && $stable(out_lsb) && $stable(out_eop))); // R7

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R6

endmodule

// File: rtl/mlc_lsb_parity.sv
module mlc_lsb_parity #(
    parameter int R1_W = 10,
    parameter int R2_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            red1_ld,
    input  logic [R1_W-1:0] red1_in,
    input  logic            red2_ld,
    input  logic [R2_W-1:0] red2_in,
    output logic [R1_W-1:0] msb_par,
    output logic [R1_W-1:0] lsb_par,
    output logic            par_valid
);

    localparam int HI_W = R2_W - R1_W;

    typedef struct packed {
        logic [R1_W-1:0] red1;
        logic [R1_W-1:0] red2_lo;
        logic            have1;
        logic            have2;
        logic [R1_W-1:0] par;
        logic            vld;
    } par_t;

    par_t par_d, par_q;

    logic [HI_W-1:0] unused_red2_hi;
    assign unused_red2_hi = red2_in[R2_W-1:R1_W];

    always_comb begin
        par_d = par_q;
        if (red1_ld) begin
            par_d.red1  = red1_in;
            par_d.have1 = 1'b1;
        end
        if (red2_ld) begin
            par_d.red2_lo = red2_in[R1_W-1:0];
            par_d.have2   = 1'b1;
        end
        par_d.par = par_q.red1 ^ par_q.red2_lo;
        par_d.vld = par_q.have1 && par_q.have2 && !red1_ld && !red2_ld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '0;
        end else begin
            par_q <= par_d;
        end
    end

    assign msb_par   = par_q.red1;
    assign lsb_par   = par_q.par;
    assign par_valid = par_q.vld;

    AST_PAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (red1_ld || red2_ld) |=> !par_valid); // R10

    AST_PAR_RISE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_valid) |-> $past(red1_ld || red2_ld, 2)); // R9

endmodule

// File: rtl/mlc_pair_level_fix.sv
module mlc_pair_level_fix #(
    parameter int LANES = 1,
    parameter int R1_W  = 10,
    parameter int R2_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] in_msb,
    input  logic [LANES-1:0] in_lsb,
    input  logic [LANES-1:0] in_flag,
    input  logic             in_eop,
    output logic [LANES-1:0] sum_bits,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_msb,
    output logic [LANES-1:0] out_lsb,
    output logic             out_eop,
    input  logic             red1_ld,
    input  logic [R1_W-1:0]  red1_in,
    input  logic             red2_ld,
    input  logic [R2_W-1:0]  red2_in,
    output logic [R1_W-1:0]  msb_par,
    output logic [R1_W-1:0]  lsb_par,
    output logic             par_valid
);

    logic [LANES-1:0] fix_msb;
    logic [LANES-1:0] fix_lsb;

    assign sum_bits = in_msb ^ in_lsb;

    mlc_level_remap #(.LANES(LANES)) u_remap (
        .in_msb  (in_msb),
        .in_lsb  (in_lsb),
        .in_flag (in_flag),
        .out_msb (fix_msb),
        .out_lsb (fix_lsb)
    );

    mlc_cell_stage #(.LANES(LANES)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_msb    (fix_msb),
        .in_lsb    (fix_lsb),
        .in_eop    (in_eop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_msb   (out_msb),
        .out_lsb   (out_lsb),
        .out_eop   (out_eop)
    );

    mlc_lsb_parity #(.R1_W(R1_W), .R2_W(R2_W)) u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .red1_ld   (red1_ld),
        .red1_in   (red1_in),
        .red2_ld   (red2_ld),
        .red2_in   (red2_in),
        .msb_par   (msb_par),
        .lsb_par   (lsb_par),
        .par_valid (par_valid)
    );

endmodule

// File: tb/mlc_pair_level_fix_tb.sv
`timescale 1ns/1ps
module mlc_pair_level_fix_tb;

    localparam int LN  = 1;
    localparam int W1  = 10;
    localparam int W2  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
    logic [LN-1:0] in_msb = '0, in_lsb = '0, in_flag = '0;
    logic in_ready, out_valid, out_eop, par_valid;
    logic [LN-1:0] sum_bits, out_msb, out_lsb;
    logic red1_ld = 1'b0, red2_ld = 1'b0;
    logic [W1-1:0] red1_in = '0;
    logic [W2-1:0] red2_in = '0;
    logic [W1-1:0] msb_par, lsb_par;

    always #5 clk = ~clk;

    mlc_pair_level_fix #(.LANES(LN), .R1_W(W1), .R2_W(W2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_msb(in_msb), .in_lsb(in_lsb), .in_flag(in_flag), .in_eop(in_eop),
        .sum_bits(sum_bits), .out_valid(out_valid), .out_ready(out_ready),
        .out_msb(out_msb), .out_lsb(out_lsb), .out_eop(out_eop),
        .red1_ld(red1_ld), .red1_in(red1_in), .red2_ld(red2_ld), .red2_in(red2_in),
        .msb_par(msb_par), .lsb_par(lsb_par), .par_valid(par_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] expq[$];       // {msb, lsb, flag, eop} of accepted input
    bit hold_prev = 1'b0;
    logic [2:0] hold_val;
    bit accepted;
    logic [W1-1:0] e1;
    logic [W2-1:0] e2;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model_fix(input logic m, input logic l, input logic f);
        if (!f) return {m, l};
        case ({m, l})
            2'b11:   return 2'b10;
            2'b10:   return 2'b11;
            2'b00:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // One cycle: set drives at negedge, evaluate handshakes before the next posedge.
    task automatic step(input logic v, input logic m, input logic l, input logic f,
                        input logic e, input logic rdy);
        logic [3:0] it;
        logic [1:0] ex;
        string tag;
        @(negedge clk);
        in_valid = v; in_msb = m; in_lsb = l; in_flag = f; in_eop = e; out_ready = rdy;
        #1;
        check(sum_bits == (in_msb ^ in_lsb), "R5", sum_bits, in_msb ^ in_lsb);
        check(in_ready == (!out_valid || out_ready), "R6 ready", in_ready, !out_valid || out_ready);
        if (hold_prev) begin
            check(out_valid && {out_msb, out_lsb, out_eop} == hold_val, "R7",
                  {out_valid, out_msb, out_lsb, out_eop}, {1'b1, hold_val});
        end
        hold_prev = out_valid && !out_ready;
        hold_val  = {out_msb, out_lsb, out_eop};
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6 extra beat", 1, 0);
            end else begin
                it = expq.pop_front();
                ex = model_fix(it[3], it[2], it[1]);
                if (!it[1]) tag = "R2";
                else if (it[3]) tag = "R3";
                else tag = "R4";
                check({out_msb, out_lsb} == ex, tag, {out_msb, out_lsb}, ex);
                check(out_eop == it[0], "R8", out_eop, it[0]);
            end
        end
        accepted = v && in_ready;
        if (accepted) expq.push_back({m, l, f, e});
    endtask

    task automatic send(input logic m, input logic l, input logic f, input logic e, input int rdy_pct);
        do begin
            step(1'b1, m, l, f, e, ($urandom % 100) < rdy_pct);
        end while (!accepted);
    endtask

    task automatic drain();
        int guard = 0;
        while ((expq.size() != 0 || out_valid) && guard < 100) begin
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            guard++;
        end
        check(expq.size() == 0, "R6 lost beat", expq.size(), 0);
    endtask

    task automatic load(input bit l1, input logic [W1-1:0] v1, input bit l2, input logic [W2-1:0] v2);
        logic [W1-1:0] ep;
        @(negedge clk);
        red1_ld = l1; red1_in = v1; red2_ld = l2; red2_in = v2;
        if (l1) e1 = v1;
        if (l2) e2 = v2;
        @(negedge clk);
        red1_ld = 1'b0; red2_ld = 1'b0;
        #1;
        check(par_valid == 1'b0, "R10 drop", par_valid, 0);
        @(negedge clk);
        #1;
        ep = e1 ^ e2[W1-1:0];
        check(par_valid == 1'b1, "R9 valid", par_valid, 1);
        check(lsb_par == ep, "R9 value", lsb_par, ep);
        check(msb_par == e1, "R9 msb word", msb_par, e1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(par_valid == 1'b0, "R1 par_valid", par_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0 && par_valid == 1'b0, "R1 after release", {out_valid, par_valid}, 0);

        // Directed: every state, unflagged and flagged, no stalls
        for (int s = 0; s < 8; s++) begin
            send(s[1], s[0], s[2], s == 7, 100);
        end
        drain();
        // Directed: same states under heavy stalls
        for (int s = 0; s < 8; s++) begin
            send(s[0], s[1], s[2], s == 3, 30);
        end
        drain();
        // Random stream
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 6) == 0) begin
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ($urandom % 2) == 1);
            end else begin
                send($urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 8) == 0, 1 + ($urandom % 100));
            end
        end
        drain();

        // Parity: one word alone never becomes valid
        @(negedge clk);
        red1_ld = 1'b1; red1_in = 10'h2A5; e1 = 10'h2A5;
        @(negedge clk);
        red1_ld = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(par_valid == 1'b0, "R9 single word", par_valid, 0);
        check(msb_par == e1, "R9 msb word", msb_par, e1);
        // Second word arrives, then single-word reloads, then joint loads
        load(1'b0, '0, 1'b1, 20'hF0F3C);
        load(1'b0, '0, 1'b1, 20'h0_03FF);
        load(1'b1, 10'h155, 1'b0, '0);
        for (int i = 0; i < 20; i++) begin
            load(1'b1, W1'($urandom), 1'b1, W2'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule